// File: doc/BRIEF.md
# Raster Beam Counter with Position Interrupts

This block stands in for the beam-position hardware of a CRT-based arcade machine whose processor runs from a 1 MHz enable. A 14-bit counter advances once per enable tick and models where the electron beam is on the screen. It does not wrap straight back to zero. After its first overflow it jumps to 16128 and counts the last 256 values a second time. This stretches each frame to 16640 ticks, which is about 16.6 ms or 60 Hz.

The top six counter bits are the vertical position, and the processor reads them as a byte. Two interrupt sources are taken from the counter. The first is a periodic timer of about 4 ms, taken from counter bit 11. The second is a bottom-of-screen event that fires when the four uppermost bits become all ones. The two sources share one request line. Each source stays raised for a minimum hold window of ticks, so a processor that is part-way through a long instruction still sees it. A source drops only once both of these have happened: the processor has acknowledged it, and the window has run out.

Top module: `raster_irq_top`

## Requirements
- R1: While reset is asserted, and directly after it is released, the beam count is 0, the position byte is 0 and the request line is low. Reset takes effect as soon as it is asserted, without waiting for a clock edge.
- R2: The beam count changes only in a cycle in which the tick input is high. Each tick below 16383 adds exactly one.
- R3: The first tick that arrives at count 16383 in a frame loads 16128.
- R4: The next tick at 16383, which ends the stretched segment, loads 0. A complete frame is therefore 16640 ticks.
- R5: The timer source (acknowledge bit 0) is raised by a tick that takes bit 11 of the count from 0 to 1. This happens at counts 2048, 6144, 10240 and 14336, and the source is raised in the same cycle the count reaches that value.
- R6: The bottom-of-screen source (acknowledge bit 1) is raised by a tick that takes count bits 13 to 10 to all ones, at count 15360. It is not raised again during the stretched segment.
- R7: The position byte equals count bits 13 to 8 in byte bits 7 to 2, with byte bits 1 and 0 always zero.
- R8: A raised source keeps the request line high for at least 100 ticks. If the source is acknowledged early, it drops with the 100th tick after the tick that raised it.
- R9: A source that is not acknowledged stays raised for as long as no acknowledge arrives. An acknowledge that arrives after the window has expired clears the source at the next clock edge.
- R10: An acknowledge bit for a source that is not raised has no effect. A later event of that source still needs its own acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 1 MHz enable, one clock wide |
| ack_i | input | 2 | Acknowledge pulses, bit 0 timer, bit 1 bottom-of-screen |
| beam_o | output | 14 | Beam counter value |
| vpos_o | output | 8 | Readable vertical-position byte |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A directed pass runs one full frame with an unbroken tick stream. It places acknowledges at three points: before the window expires, long after it has expired, and before any event has occurred. These three placements separate the early-release, late-release and ignored-acknowledge rules. The same pass crosses both overflows, which tells the reload to 16128 apart from the final wrap to zero. A random pass then uses gapped ticks and scattered acknowledges on both bits. This shows that the counter freezes on idle cycles, and that events which land while a source is still pending restart its window.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int NSRC       = 2;
  localparam int SRC_TIMER  = 0;
  localparam int SRC_LINE   = 1;
  localparam int BYTE_W     = 8;
endpackage

// File: rtl/raster_rst_sync.sv
module raster_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/raster_beam_cnt.sv
module raster_beam_cnt
  import raster_pkg::*;
#(
  parameter int CNT_W     = 14,
  parameter int RELOAD    = 16128,
  parameter int TIMER_BIT = 11,
  parameter int LINE_BITS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [NSRC-1:0]  ev_o
);
  localparam logic [CNT_W-1:0] RELOAD_V = CNT_W'(RELOAD);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             str_q, str_d;   // high while replaying the stretched segment

  function automatic logic line_zone(input logic [CNT_W-1:0] v);
    return &v[CNT_W-1 -: LINE_BITS];
  endfunction

  always_comb begin
    cnt_d = cnt_q;
    str_d = str_q;
    if (tick_i) begin
      if (&cnt_q) begin
        cnt_d = str_q ? '0 : RELOAD_V;
        str_d = ~str_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      str_q <= 1'b0;
    end else if (tick_i) begin
      cnt_q <= cnt_d;
      str_q <= str_d;
    end
  end

  // events are taken from the rising edge of the next count
  assign ev_o[SRC_TIMER] = ~cnt_q[TIMER_BIT] & cnt_d[TIMER_BIT];
  assign ev_o[SRC_LINE]  = ~line_zone(cnt_q) & line_zone(cnt_d);
  assign cnt_o           = cnt_q;
endmodule

// File: rtl/raster_irq_hold.sv
module raster_irq_hold #(
  parameter int HOLD = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ev_i,
  input  logic ack_i,
  output logic pend_o
);
  localparam int HW = $clog2(HOLD + 1);
  localparam logic [HW-1:0] HOLD_V = HW'(HOLD);

  logic          pend_q, pend_d;
  logic          ackd_q, ackd_d;
  logic [HW-1:0] hold_q, hold_d;

  always_comb begin
    pend_d = pend_q;
    ackd_d = ackd_q;
    hold_d = hold_q;
    if (ev_i) begin
      pend_d = 1'b1;
      ackd_d = 1'b0;
      hold_d = HOLD_V;
    end else if (pend_q) begin
      if (tick_i && (hold_q != '0)) hold_d = hold_q - 1'b1;
      if (ack_i) ackd_d = 1'b1;
      if (ackd_d && (hold_d == '0)) begin
        pend_d = 1'b0;
        ackd_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      ackd_q <= 1'b0;
      hold_q <= '0;
    end else begin
      pend_q <= pend_d;
      ackd_q <= ackd_d;
      hold_q <= hold_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/raster_irq_top.sv
module raster_irq_top
  import raster_pkg::*;
#(
  parameter int CNT_W     = 14,
  parameter int RELOAD    = 16128,
  parameter int TIMER_BIT = 11,
  parameter int LINE_BITS = 4,
  parameter int VPOS_W    = 6,
  parameter int HOLD      = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [NSRC-1:0]   ack_i,
  output logic [CNT_W-1:0]  beam_o,
  output logic [BYTE_W-1:0] vpos_o,
  output logic              irq_o
);
  localparam int PAD_W = BYTE_W - VPOS_W;

  logic            rst_sync_n;
  logic [NSRC-1:0] ev;
  logic [NSRC-1:0] pend;

  raster_rst_sync #(.STAGES(2)) rst_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  raster_beam_cnt #(
    .CNT_W(CNT_W), .RELOAD(RELOAD), .TIMER_BIT(TIMER_BIT), .LINE_BITS(LINE_BITS)
  ) cnt_i (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .tick_i (tick_i),
    .cnt_o  (beam_o),
    .ev_o   (ev)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    raster_irq_hold #(.HOLD(HOLD)) hold_i (
      .clk_i  (clk_i),
      .rst_ni (rst_sync_n),
      .tick_i (tick_i),
      .ev_i   (ev[s]),
      .ack_i  (ack_i[s]),
      .pend_o (pend[s])
    );
  end

  if (PAD_W > 0) begin : g_pad
    assign vpos_o = {beam_o[CNT_W-1 -: VPOS_W], {PAD_W{1'b0}}};
  end else begin : g_nopad
    assign vpos_o = beam_o[CNT_W-1 -: BYTE_W];
  end

  assign irq_o = |pend;
endmodule

// File: rtl/raster_irq_chk.sv
module raster_irq_chk
  import raster_pkg::*;
#(
  parameter int CNT_W  = 14,
  parameter int RELOAD = 16128,
  parameter int HOLD   = 100
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             tick_i,
  input logic [CNT_W-1:0] beam_o,
  input logic             irq_o,
  input logic [NSRC-1:0]  ev
);
  localparam int SW = $clog2(HOLD + 1) + 1;
  logic [SW-1:0] since_ev;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)                              since_ev <= '0;
    else if (|ev)                            since_ev <= '0;
    else if (tick_i && since_ev < SW'(HOLD)) since_ev <= since_ev + 1'b1;
  end

  a_r2_idle_freeze: assert property (@(posedge clk_i) disable iff (!rst_n)
    !tick_i |=> $stable(beam_o));
  a_r2_step_one: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tick_i && !(&beam_o)) |=> (beam_o == CNT_W'($past(beam_o) + 1'b1)));
  a_r3_top_wrap: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tick_i && (&beam_o)) |=> (beam_o == CNT_W'(RELOAD) || beam_o == '0));
  a_r5_event_raises: assert property (@(posedge clk_i) disable iff (!rst_n)
    (|ev) |=> irq_o);
  a_r8_min_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(irq_o) |-> (since_ev >= SW'(HOLD)));
endmodule

bind raster_irq_top raster_irq_chk #(
  .CNT_W(CNT_W), .RELOAD(RELOAD), .HOLD(HOLD)
) chk_i (
  .clk_i  (clk_i),
  .rst_n  (rst_sync_n),
  .tick_i (tick_i),
  .beam_o (beam_o),
  .irq_o  (irq_o),
  .ev     (ev)
);

// File: tb/raster_irq_top_tb_top.sv
`timescale 1ns/1ps
module raster_irq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [1:0]  ack = 2'b00;
  logic [13:0] beam;
  logic [7:0]  vpos;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  raster_irq_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ack_i(ack),
    .beam_o(beam), .vpos_o(vpos), .irq_o(irq)
  );

  // ---------------- reference built from the requirements ----------------
  logic [13:0] m_cnt;
  logic        m_str;
  logic [1:0]  m_pend, m_ackd;
  int          m_hold [2];

  function automatic logic [13:0] f_next(input logic [13:0] c, input logic st);
    if (c == 14'h3FFF) return st ? 14'd0 : 14'd16128;   // R3 / R4
    return c + 14'd1;                                    // R2
  endfunction

  function automatic logic [1:0] f_events(input logic [13:0] o, input logic [13:0] n);
    logic [1:0] e;
    e[0] = !o[11] && n[11];                              // R5
    e[1] = (o[13:10] != 4'hF) && (n[13:10] == 4'hF);     // R6
    return e;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_str <= 1'b0; m_pend <= '0; m_ackd <= '0;
      m_hold[0] <= 0; m_hold[1] <= 0;
    end else begin
      logic [13:0] n;
      logic [1:0]  e;
      n = tick ? f_next(m_cnt, m_str) : m_cnt;
      e = tick ? f_events(m_cnt, n) : 2'b00;
      if (tick && m_cnt == 14'h3FFF) m_str <= ~m_str;
      m_cnt <= n;
      for (int s = 0; s < 2; s++) begin
        if (e[s]) begin
          m_pend[s] <= 1'b1; m_ackd[s] <= 1'b0; m_hold[s] <= 100;
        end else if (m_pend[s]) begin
          int  h;
          logic a;
          h = (tick && m_hold[s] > 0) ? m_hold[s] - 1 : m_hold[s];
          a = m_ackd[s] || ack[s];                       // R10: only while raised
          m_hold[s] <= h;
          if (a && h == 0) begin m_pend[s] <= 1'b0; m_ackd[s] <= 1'b0; end
          else m_ackd[s] <= a;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("R2/R3/R4 beam vs model", beam, m_cnt);
      chk("R7 vpos vs model", vpos, {m_cnt[13:8], 2'b00});
      chk("R8/R9/R10 irq vs model", irq, |m_pend);
    end
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic pulse_ack(input logic [1:0] m);
    @(negedge clk); ack = m;
    @(negedge clk); ack = 2'b00;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; tick = 1'b0; ack = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7331));
    do_reset();
    chk("R1 beam after reset", beam, 0);
    chk("R1 vpos after reset", vpos, 0);
    chk("R1 irq after reset", irq, 0);
    repeat (5) @(negedge clk);
    chk("R2 no tick keeps count", beam, 0);

    run(2047);
    chk("R5 count before first timer event", beam, 2047);
    chk("R5 irq low before 2048", irq, 0);
    run(1);
    chk("R5 irq raised at 2048", irq, 1);
    pulse_ack(2'b01);
    chk("R2 ack cycles keep count", beam, 2048);
    run(99);
    chk("R8 still held at 99 ticks", irq, 1);
    run(1);
    chk("R8 early ack drops at 100th tick", irq, 0);
    chk("R8 count at release", beam, 2148);

    run(3996);
    chk("R5 irq raised at 6144", irq, 1);
    run(300);
    chk("R9 unacked source stays raised", irq, 1);
    pulse_ack(2'b01);
    chk("R9 late ack clears", irq, 0);

    pulse_ack(2'b11);
    chk("R10 idle ack leaves irq low", irq, 0);
    run(3796);
    chk("R5 irq raised at 10240", irq, 1);
    run(150);
    chk("R10 earlier idle ack not remembered", irq, 1);
    pulse_ack(2'b01);
    chk("R9 ack after window clears", irq, 0);

    run(3946);
    chk("R5 count at 14336", beam, 14336);
    chk("R5 irq raised at 14336", irq, 1);
    pulse_ack(2'b01);
    run(100);
    chk("R8 release at 14436", irq, 0);
    run(923);
    chk("R6 irq low at 15359", irq, 0);
    run(1);
    chk("R6 irq raised at 15360", irq, 1);
    chk("R7 vpos at 15360", vpos, 8'hF0);
    pulse_ack(2'b01);
    run(100);
    chk("R10 wrong-bit ack ignored", irq, 1);
    pulse_ack(2'b10);
    chk("R9 line source cleared", irq, 0);
    chk("R2 count at 15460", beam, 15460);
    run(923);
    chk("R2 count at top", beam, 16383);
    chk("R7 vpos at top", vpos, 8'hFC);
    run(1);
    chk("R3 first overflow reloads", beam, 16128);
    chk("R6 no event entering stretch", irq, 0);
    run(255);
    chk("R3 stretched segment top", beam, 16383);
    run(1);
    chk("R4 second overflow to zero", beam, 0);
    chk("R6 no event in stretch", irq, 0);

    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      tick = ($urandom % 4) != 0;
      ack  = (($urandom % 48) == 0) ? 2'($urandom) : 2'b00;
    end
    @(negedge clk); tick = 1'b0; ack = 2'b00;

    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R1 async reset clears beam", beam, 0);
    chk("R1 async reset clears irq", irq, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 beam after release", beam, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule